// File: doc/BRIEF.md
# PCI Type-0 Configuration Header with Function Reset

This block holds the 64-byte configuration header of one PCI function as sixteen dword registers. Software reaches it through a simple dword port: a dword index, four byte enables, write data and a combinational read path. Every bit has a write mask that is fixed at build time. A config write changes a bit only where its byte is enabled and the mask marks the bit writable, so identity fields, type bits and the low address bits of a base address register (BAR) cannot be altered. Writing all ones to a BAR and reading it back returns the size mask, which is the usual way to size a BAR.

A one-cycle function reset pulse puts the function back into a defined state without a full power-on reset. It clears the writable command bits and keeps the read-only ones. It zeroes the cache-line-size and interrupt-line bytes, drops any pending legacy interrupt, and rewrites each implemented BAR to its type bits. A 64-bit memory BAR is handled as a two-dword value, so its upper dword is cleared as well. A build parameter sets the multifunction flag in the header-type byte. A bridge variant also makes the 16-bit bridge-control field writable.

Top module: `cfghdr_space`

## Requirements
- R1: After power-on reset, dword 0 reads {DEVICE_ID, VENDOR_ID}, dword 2 reads {CLASS_CODE, REV_ID}, the command field (dword 1 bits 15:0) reads CMD_RESET_VAL, and each BAR (dwords 4 to 9) reads its type bits only: I/O = 0x1, 32-bit memory = 0x0, 64-bit memory = 0x4, upper dword of a 64-bit BAR = 0x0.
- R2: A write changes a bit only where its byte enable (cfg_be[k] covers bits 8k+7:8k) and its mask bit are both 1. Dword 0, the status half of dword 1 and other read-only fields never change.
- R3: Writing 0xFFFFFFFF to an implemented BAR reads back as the size mask ORed with the type bits. Address bits below the BAR size read zero.
- R4: For a 64-bit memory BAR, the following dword holds address bits 63:32 and is writable in all 32 bits.
- R5: A BAR with size zero that is not the upper half of a 64-bit BAR reads 0 and ignores writes.
- R6: A function reset clears every command bit whose CMD_WMASK bit is 1 and leaves the other command bits unchanged.
- R7: A function reset sets cache line size (dword 3 bits 7:0) and interrupt line (dword 15 bits 7:0) to zero. Latency timer (dword 3 bits 15:8) keeps its value.
- R8: A function reset rewrites each implemented BAR to its type bits and clears the upper dword of a 64-bit memory BAR.
- R9: The header-type byte is dword 3 bits 23:16. Bit 23 equals MULTIFUNC. Bits 22:16 are 0 for the normal variant and 1 for the bridge variant.
- R10: In the bridge variant, dword 15 bits 31:16 (bridge control) are writable in all 16 bits and are not cleared by a function reset. In the normal variant those bits read {MAX_LAT, MIN_GNT}.
- R11: A pulse on irq_set makes the interrupt pending. Pending shows in status bit 3 (dword 1 bit 19). int_out is pending gated by command bit 10 (interrupt disable). irq_clr or a function reset clears pending.
- R12: A function reset that coincides with a config write wins: the written fields end up in their reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_wr | input | 1 | Config write strobe |
| cfg_addr | input | 4 | Dword index into the 64-byte header |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| flr | input | 1 | Function reset pulse |
| irq_set | input | 1 | Raise the legacy interrupt pending state |
| irq_clr | input | 1 | Drop the legacy interrupt pending state |
| int_out | output | 1 | Legacy interrupt request |

## Verification
The bench builds two instances that share their stimulus. The first keeps the default BAR set (a 32-byte I/O BAR, a 4 KiB 32-bit memory BAR and a 1 MiB 64-bit memory BAR, followed by two empty slots), sets MULTIFUNC and gives the command register a read-only bit that is set at power-on. That makes sizing, programming and function reset reachable on all three BAR kinds and on an unimplemented slot, and it shows that read-only command bits survive a reset. The second instance is the bridge variant with the multifunction flag clear. It exposes the other header-type encoding and a bridge-control field that must stay writable and survive a function reset.

// File: rtl/cfghdr_pkg.sv
package cfghdr_pkg;

  localparam int NUM_BARS  = 6;
  localparam int NUM_DW    = 16;
  localparam int BAR_FIRST = 4;

  typedef enum logic [1:0] {
    BAR_NONE  = 2'd0,
    BAR_IO32  = 2'd1,
    BAR_MEM32 = 2'd2,
    BAR_MEM64 = 2'd3
  } bar_kind_e;

  typedef logic [NUM_BARS-1:0][1:0] bar_kinds_t;
  typedef logic [NUM_BARS-1:0][5:0] bar_sizes_t;

  // Fixed low bits a BAR presents for its kind
  function automatic logic [31:0] bar_type_bits(logic [1:0] kind);
    case (kind)
      BAR_IO32:  return 32'h0000_0001;
      BAR_MEM64: return 32'h0000_0004;
      default:   return 32'h0000_0000;
    endcase
  endfunction

  // Writable address bits of a BAR of size 2**szlog2 bytes
  function automatic logic [31:0] bar_addr_mask(logic [1:0] kind, logic [5:0] szlog2);
    logic [4:0]  s;
    logic [31:0] m;
    if (kind == BAR_NONE || szlog2 == 6'd0) return 32'h0;
    s = (szlog2 > 6'd31) ? 5'd31 : szlog2[4:0];
    m = ~((32'h1 << s) - 32'h1);
    if (kind == BAR_IO32) return m & ~32'h3;
    return m & ~32'hF;
  endfunction

  // True when slot idx carries bits 63:32 of the BAR below it
  function automatic logic bar_is_upper(bar_kinds_t kinds, int idx);
    if (idx == 0) return 1'b0;
    return kinds[idx-1] == BAR_MEM64;
  endfunction

  function automatic logic [31:0] be_to_mask(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] merge_bits(logic [31:0] old_v, logic [31:0] new_v,
                                             logic [31:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/cfghdr_bar_bank.sv
module cfghdr_bar_bank
  import cfghdr_pkg::*;
#(
  parameter bar_kinds_t BAR_KIND   = '0,
  parameter bar_sizes_t BAR_SZLOG2 = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flr,
  input  logic                      wr_en,
  input  logic [2:0]                wr_idx,
  input  logic [31:0]               wr_bytes,
  input  logic [31:0]               wdata,
  output logic [NUM_BARS-1:0][31:0] bar_q
);

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam logic        UPPER = bar_is_upper(BAR_KIND, i);
    localparam logic        IMPL  = UPPER || (BAR_KIND[i] != BAR_NONE && BAR_SZLOG2[i] != 6'd0);
    localparam logic [31:0] WMASK = UPPER ? 32'hFFFF_FFFF :
                                    (IMPL ? bar_addr_mask(BAR_KIND[i], BAR_SZLOG2[i]) : 32'h0);
    localparam logic [31:0] RVAL  = (UPPER || !IMPL) ? 32'h0 : bar_type_bits(BAR_KIND[i]);

    logic hit;
    assign hit = wr_en && (wr_idx == 3'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bar_q[i] <= RVAL;
      else if (flr && IMPL)
        bar_q[i] <= RVAL;
      else if (hit && !flr)
        bar_q[i] <= merge_bits(bar_q[i], wdata, wr_bytes & WMASK);
    end

    if (IMPL) begin : g_chk
      AST_BAR_FLR_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        flr |=> (bar_q[i] == RVAL)); // R8
    end
    AST_BAR_RO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !flr) |=> (((bar_q[i] ^ $past(bar_q[i])) & ~WMASK) == 32'h0)); // R2
  end

endmodule

// File: rtl/cfghdr_ctrl_regs.sv
module cfghdr_ctrl_regs
  import cfghdr_pkg::*;
#(
  parameter logic [15:0] CMD_WMASK     = 16'h0547,
  parameter logic [15:0] CMD_RESET_VAL = 16'h0000,
  parameter bit          IS_BRIDGE     = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flr,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [31:0] wr_bytes,
  input  logic [31:0] wdata,
  output logic [15:0] cmd_q,
  output logic [7:0]  cache_line_q,
  output logic [7:0]  lat_timer_q,
  output logic [7:0]  int_line_q,
  output logic [15:0] bridge_ctl_q
);

  localparam logic [3:0] DW_CMD   = 4'd1;
  localparam logic [3:0] DW_MISC  = 4'd3;
  localparam logic [3:0] DW_INTR  = 4'd15;

  logic wr_cmd, wr_misc, wr_intr;
  assign wr_cmd  = wr_en && !flr && (wr_idx == DW_CMD);
  assign wr_misc = wr_en && !flr && (wr_idx == DW_MISC);
  assign wr_intr = wr_en && !flr && (wr_idx == DW_INTR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q        <= CMD_RESET_VAL;
      cache_line_q <= '0;
      lat_timer_q  <= '0;
      int_line_q   <= '0;
    end else if (flr) begin
      cmd_q        <= cmd_q & ~CMD_WMASK;
      cache_line_q <= '0;
      int_line_q   <= '0;
    end else begin
      if (wr_cmd)
        cmd_q <= 16'(merge_bits({16'h0, cmd_q}, wdata, wr_bytes & {16'h0, CMD_WMASK}));
      if (wr_misc) begin
        cache_line_q <= 8'(merge_bits({24'h0, cache_line_q}, wdata, wr_bytes & 32'hFF));
        lat_timer_q  <= 8'(merge_bits({24'h0, lat_timer_q}, wdata >> 8, (wr_bytes >> 8) & 32'hFF));
      end
      if (wr_intr)
        int_line_q <= 8'(merge_bits({24'h0, int_line_q}, wdata, wr_bytes & 32'hFF));
    end
  end

  if (IS_BRIDGE) begin : g_bctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bridge_ctl_q <= '0;
      else if (wr_intr)
        bridge_ctl_q <= 16'(merge_bits({16'h0, bridge_ctl_q}, wdata >> 16, wr_bytes >> 16));
    end
  end else begin : g_no_bctl
    assign bridge_ctl_q = '0;
  end

  AST_CMD_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flr |=> ((cmd_q & CMD_WMASK) == 16'h0)); // R6
  AST_CMD_RO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((cmd_q ^ $past(cmd_q)) & ~CMD_WMASK) == 16'h0)); // R6
  AST_LINES_FLR: assert property (@(posedge clk) disable iff (!rst_n)
    flr |=> (cache_line_q == 8'h0 && int_line_q == 8'h0)); // R7
  AST_LAT_FLR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    flr |=> $stable(lat_timer_q)); // R7

endmodule

// File: rtl/cfghdr_intx.sv
module cfghdr_intx (
  input  logic clk,
  input  logic rst_n,
  input  logic flr,
  input  logic irq_set,
  input  logic irq_clr,
  input  logic int_disable,
  output logic pending_q,
  output logic int_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pending_q <= 1'b0;
    else if (flr)
      pending_q <= 1'b0;
    else if (irq_set)
      pending_q <= 1'b1;
    else if (irq_clr)
      pending_q <= 1'b0;
  end

  assign int_out = pending_q && !int_disable;

  AST_PEND_FLR: assert property (@(posedge clk) disable iff (!rst_n)
    flr |=> !pending_q); // R11
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set && !flr) |=> pending_q); // R11

endmodule

// File: rtl/cfghdr_space.sv
module cfghdr_space
  import cfghdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'hABCD,
  parameter logic [15:0] DEVICE_ID     = 16'h0042,
  parameter logic [7:0]  REV_ID        = 8'h01,
  parameter logic [23:0] CLASS_CODE    = 24'h020000,
  parameter logic [15:0] SUBSYS_VID    = 16'h0000,
  parameter logic [15:0] SUBSYS_ID     = 16'h0000,
  parameter logic [15:0] STATUS_RO     = 16'h0000,
  parameter logic [15:0] CMD_WMASK     = 16'h0547,
  parameter logic [15:0] CMD_RESET_VAL = 16'h0000,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GNT       = 8'h00,
  parameter logic [7:0]  MAX_LAT       = 8'h00,
  parameter bit          MULTIFUNC     = 1'b0,
  parameter bit          IS_BRIDGE     = 1'b0,
  parameter bar_kinds_t  BAR_KIND      = {2'd0, 2'd0, 2'd0, 2'd3, 2'd2, 2'd1},
  parameter bar_sizes_t  BAR_SZLOG2    = {6'd0, 6'd0, 6'd0, 6'd20, 6'd12, 6'd5}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        flr,
  input  logic        irq_set,
  input  logic        irq_clr,
  output logic        int_out
);

  localparam logic [7:0] HDR_TYPE = {MULTIFUNC, 7'(IS_BRIDGE ? 1 : 0)};
  localparam logic [3:0] BAR_LAST = 4'(BAR_FIRST + NUM_BARS - 1);

  // Named internal events
  logic [31:0] wr_bytes;
  logic        bar_wr;
  logic [2:0]  bar_idx;
  logic [NUM_BARS-1:0][31:0] bar_q;
  logic [15:0] cmd_q, bridge_ctl_q, status_w;
  logic [7:0]  cache_line_q, lat_timer_q, int_line_q;
  logic        pending_q;

  assign wr_bytes = be_to_mask(cfg_be);
  assign bar_wr   = cfg_wr && (cfg_addr >= 4'(BAR_FIRST)) && (cfg_addr <= BAR_LAST);
  assign bar_idx  = 3'(cfg_addr - 4'(BAR_FIRST));

  cfghdr_bar_bank #(
    .BAR_KIND   (BAR_KIND),
    .BAR_SZLOG2 (BAR_SZLOG2)
  ) u_bars (
    .clk      (clk),
    .rst_n    (rst_n),
    .flr      (flr),
    .wr_en    (bar_wr),
    .wr_idx   (bar_idx),
    .wr_bytes (wr_bytes),
    .wdata    (cfg_wdata),
    .bar_q    (bar_q)
  );

  cfghdr_ctrl_regs #(
    .CMD_WMASK     (CMD_WMASK),
    .CMD_RESET_VAL (CMD_RESET_VAL),
    .IS_BRIDGE     (IS_BRIDGE)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .flr          (flr),
    .wr_en        (cfg_wr),
    .wr_idx       (cfg_addr),
    .wr_bytes     (wr_bytes),
    .wdata        (cfg_wdata),
    .cmd_q        (cmd_q),
    .cache_line_q (cache_line_q),
    .lat_timer_q  (lat_timer_q),
    .int_line_q   (int_line_q),
    .bridge_ctl_q (bridge_ctl_q)
  );

  cfghdr_intx u_intx (
    .clk         (clk),
    .rst_n       (rst_n),
    .flr         (flr),
    .irq_set     (irq_set),
    .irq_clr     (irq_clr),
    .int_disable (cmd_q[10]),
    .pending_q   (pending_q),
    .int_out     (int_out)
  );

  assign status_w = (STATUS_RO & ~16'h0008) | {12'h0, pending_q, 3'h0};

  always_comb begin
    cfg_rdata = 32'h0;
    case (cfg_addr)
      4'd0:  cfg_rdata = {DEVICE_ID, VENDOR_ID};
      4'd1:  cfg_rdata = {status_w, cmd_q};
      4'd2:  cfg_rdata = {CLASS_CODE, REV_ID};
      4'd3:  cfg_rdata = {8'h00, HDR_TYPE, lat_timer_q, cache_line_q};
      4'd11: cfg_rdata = {SUBSYS_ID, SUBSYS_VID};
      4'd15: cfg_rdata = IS_BRIDGE ? {bridge_ctl_q, INT_PIN, int_line_q}
                                   : {MAX_LAT, MIN_GNT, INT_PIN, int_line_q};
      default: begin
        if (cfg_addr >= 4'(BAR_FIRST) && cfg_addr <= BAR_LAST)
          cfg_rdata = bar_q[bar_idx];
      end
    endcase
  end

  AST_FLR_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (flr && cfg_wr) |=> (cache_line_q == 8'h0 && int_line_q == 8'h0)); // R12
  AST_INT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (status_w[3] && !cmd_q[10])); // R11

endmodule

// File: tb/cfghdr_space_bench.sv
module cfghdr_space_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        flr = 1'b0, irq_set = 1'b0, irq_clr = 1'b0;
  logic [31:0] rd_n, rd_b;
  logic        int_n, int_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cfghdr_space #(
    .MULTIFUNC     (1'b1),
    .CMD_RESET_VAL (16'h0080)
  ) u_cfghdr_space (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_n), .flr(flr), .irq_set(irq_set),
    .irq_clr(irq_clr), .int_out(int_n)
  );

  cfghdr_space #(
    .MULTIFUNC (1'b0),
    .IS_BRIDGE (1'b1)
  ) u_cfghdr_space_br (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_b), .flr(flr), .irq_set(irq_set),
    .irq_clr(irq_clr), .int_out(int_b)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] vn, output logic [31:0] vb);
    @(negedge clk);
    cfg_addr = a;
    #1;
    vn = rd_n; vb = rd_b;
  endtask

  task automatic pulse_flr();
    @(negedge clk); flr = 1'b1;
    @(negedge clk); flr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] n, b;
    rd(4'd0, n, b); check("R1 ids", n, 32'h0042_ABCD);
    rd(4'd2, n, b); check("R1 class", n, 32'h0200_0001);
    rd(4'd1, n, b); check("R1 command", n, 32'h0000_0080);
    rd(4'd4, n, b); check("R1 bar0 io", n, 32'h1);
    rd(4'd5, n, b); check("R1 bar1 mem32", n, 32'h0);
    rd(4'd6, n, b); check("R1 bar2 mem64", n, 32'h4);
    rd(4'd7, n, b); check("R1 bar3 upper", n, 32'h0);
    rd(4'd3, n, b);
    check("R9 header multifunction", n, 32'h0080_0000);
    check("R9 header bridge", b, 32'h0001_0000);
  endtask

  task automatic t_masked_write();
    logic [31:0] n, b;
    wr(4'd1, 4'b0001, 32'hFFFF_FFFF);
    rd(4'd1, n, b); check("R2 cmd low byte only", n, 32'h0000_00C7);
    wr(4'd1, 4'b0010, 32'h0000_FF00);
    rd(4'd1, n, b); check("R2 cmd high byte masked", n, 32'h0000_05C7);
    wr(4'd0, 4'b1111, 32'hFFFF_FFFF);
    rd(4'd0, n, b); check("R2 ids read-only", n, 32'h0042_ABCD);
  endtask

  task automatic t_bars();
    logic [31:0] n, b;
    for (int k = 4; k <= 9; k++) wr(4'(k), 4'b1111, 32'hFFFF_FFFF);
    rd(4'd4, n, b); check("R3 size io 32B", n, 32'hFFFF_FFE1);
    rd(4'd5, n, b); check("R3 size mem32 4K", n, 32'hFFFF_F000);
    rd(4'd6, n, b); check("R3 size mem64 1M", n, 32'hFFF0_0004);
    rd(4'd7, n, b); check("R4 mem64 upper all ones", n, 32'hFFFF_FFFF);
    rd(4'd8, n, b); check("R5 empty bar4", n, 32'h0);
    rd(4'd9, n, b); check("R5 empty bar5", n, 32'h0);
    wr(4'd4, 4'b1111, 32'h1234_5678);
    wr(4'd5, 4'b1111, 32'hABCD_E123);
    wr(4'd6, 4'b1111, 32'h8765_4321);
    wr(4'd7, 4'b1111, 32'h0000_00AB);
    rd(4'd4, n, b); check("R3 program io", n, 32'h1234_5661);
    rd(4'd5, n, b); check("R3 program mem32", n, 32'hABCD_E000);
    rd(4'd6, n, b); check("R3 program mem64 low", n, 32'h8760_0004);
    rd(4'd7, n, b); check("R4 program mem64 high", n, 32'h0000_00AB);
  endtask

  task automatic t_flr();
    logic [31:0] n, b;
    wr(4'd1, 4'b0011, 32'h0000_FFFF);
    wr(4'd3, 4'b1111, 32'hFFFF_FFFF);
    wr(4'd15, 4'b1111, 32'hFFFF_FFFF);
    rd(4'd15, n, b);
    check("R10 bridge ctl writable", b, 32'hFFFF_01FF);
    check("R10 normal lat/gnt", n, 32'h0000_01FF);
    @(negedge clk); irq_set = 1'b1;
    @(negedge clk); irq_set = 1'b0;
    pulse_flr();
    rd(4'd1, n, b); check("R6 R11 cmd and pending after reset", n, 32'h0000_0080);
    rd(4'd3, n, b);
    check("R7 cache line cleared, latency kept", n, 32'h0080_FF00);
    check("R7 bridge dword3", b, 32'h0001_FF00);
    rd(4'd15, n, b);
    check("R7 int line cleared", n, 32'h0000_0100);
    check("R10 bridge ctl survives reset", b, 32'hFFFF_0100);
    rd(4'd4, n, b); check("R8 io bar type", n, 32'h1);
    rd(4'd5, n, b); check("R8 mem32 bar type", n, 32'h0);
    rd(4'd6, n, b); check("R8 mem64 bar type", n, 32'h4);
    rd(4'd7, n, b); check("R8 mem64 upper cleared", n, 32'h0);
    rd(4'd8, n, b); check("R8 empty bar untouched", n, 32'h0);
    check("R11 int low after reset", {31'h0, int_n}, 32'h0);
  endtask

  task automatic t_flr_vs_write();
    logic [31:0] n, b;
    @(negedge clk);
    flr = 1'b1; cfg_wr = 1'b1; cfg_addr = 4'd3; cfg_be = 4'b0001; cfg_wdata = 32'h0000_00AA;
    @(negedge clk);
    flr = 1'b0; cfg_wr = 1'b0; cfg_be = '0;
    rd(4'd3, n, b); check("R12 reset wins over write", n, 32'h0080_FF00);
  endtask

  task automatic t_irq();
    logic [31:0] n, b;
    @(negedge clk); irq_set = 1'b1;
    @(negedge clk); irq_set = 1'b0;
    rd(4'd1, n, b); check("R11 status pending", n, 32'h0008_0080);
    check("R11 int asserted", {31'h0, int_n}, 32'h1);
    wr(4'd1, 4'b0011, 32'h0000_0400);
    rd(4'd1, n, b); check("R11 disable set", n, 32'h0008_0480);
    check("R11 int masked", {31'h0, int_n}, 32'h0);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    rd(4'd1, n, b); check("R11 pending cleared", n, 32'h0000_0480);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masked_write();
    t_bars();
    t_flr();
    t_flr_vs_write();
    t_irq();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule